// File: doc/BRIEF.md
# Request-Driven Word Serializer

This block turns parallel data words into a serial bit stream for a downstream bit-timing stage. The downstream stage sets the pace. Each time it pulses a bit request, the serializer presents the next bit of the current word on a registered output. The serializer counts the bits of each word. When a word runs out, it asks upstream for another one with a single-cycle word request.

Upstream logic usually fetches its words from a slow memory, so it tends to have the next word ready well before the current one has finished shifting. A one-word holding register accepts that early load. The shift register is never touched by a load. The held word moves into the shift register at the word boundary, on the first request after the last bit of the current word has been taken. This keeps the tail of every word intact, including the lone 1 at the end of a sync word. If a request arrives and no word is waiting, the serializer sends filler zeros and flags an underrun.

A startup input clears the block and holds it idle. The first word is simply loaded after startup ends, and the next request begins shifting it.

Top module: `word_serializer`

## Requirements
- R1: Words are WORD_W bits wide (default 16) and are sent most significant bit first, so for the word 0x0001 the single 1 appears as the sixteenth bit.
- R2: `bit_o` takes a new value only in the cycle after a clock edge at which `bit_req_i` was high; without a request it holds its value.
- R3: After a request that takes the last bit of a word, `word_req_o` is high for exactly one cycle, provided the holding register is empty and no load arrives in that same cycle.
- R4: After a request that moves the held word into the shift register, `word_req_o` is high for one cycle unless a new load arrived in that same cycle.
- R5: `word_req_o` is never high while the holding register holds a word, and it is never high in two consecutive cycles.
- R6: A word loaded while the previous word is still shifting does not alter any remaining bit of that previous word. The loaded word follows it with no gap when requests continue.
- R7: A load that arrives while the holding register is already full replaces the held word.
- R8: A request that finds no bit left and no held word makes `bit_o` 0 and `underrun_o` 1 in the next cycle. `underrun_o` returns to 0 after the next request that is served from real data.
- R9: While `init_i` is high, requests and loads are ignored and any partly sent or held word is discarded. One cycle after a clock edge with `init_i` high, `bit_o`, `word_req_o` and `underrun_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Startup clear; holds the block idle while high |
| load_i | input | 1 | Strobe that writes `data_i` into the holding register |
| data_i | input | WORD_W | Parallel word to send |
| bit_req_i | input | 1 | Downstream request for the next bit |
| bit_o | output | 1 | Current serial bit |
| word_req_o | output | 1 | Single-cycle request for a new word |
| underrun_o | output | 1 | High while the last bit sent was filler |

## Verification
A sync word (0x0001) is shifted while the next word is loaded early. This shows whether the trailing 1 survives the load and whether the held word follows without a gap. A mixed word (0xA5C3) then distinguishes MSB-first from LSB-first order, and also tells shifting apart from stuck bits. A request with nothing loaded separates filler output from stale data. A double load into a full holding register shows replacement versus retention. Clearing the block in the middle of a word, with a load and a request applied at the same time, shows that the startup input discards state and does not pass those inputs through.

// File: rtl/ws_pkg.sv
package ws_pkg;
   // where the next bit comes from on a request
   typedef enum logic [1:0] {
      SRC_SHIFT = 2'd0,
      SRC_HOLD  = 2'd1,
      SRC_FILL  = 2'd2
   } ws_src_e;
endpackage

// File: rtl/ws_hold.sv
module ws_hold #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic              take,
   input  logic [WORD_W-1:0] data_i,
   output logic [WORD_W-1:0] word_o,
   output logic              vld_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o <= '0;
         vld_o  <= 1'b0;
      end else if (clr) begin
         word_o <= '0;
         vld_o  <= 1'b0;
      end else if (load) begin
         word_o <= data_i;
         vld_o  <= 1'b1;
      end else if (take) begin
         vld_o  <= 1'b0;
      end
   end

   // R7
   hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> (vld_o && word_o == $past(data_i)));

   // R6
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && !load && !clr) |=> $stable(word_o));
endmodule

// File: rtl/ws_shift.sv
module ws_shift
   import ws_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic              hold_vld,
   input  logic [WORD_W-1:0] hold_word,
   output logic              take_o,
   output logic              last_o,
   output logic              bit_o,
   output logic              underrun_o
);
   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] CNT_RELOAD = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

   logic [WORD_W-1:0] sreg;
   logic [WORD_W-1:0] sreg_adv, hold_adv;
   logic              head_s, head_h;
   logic [CNT_W-1:0]  cnt;
   ws_src_e           src;

   generate
      if (MSB_FIRST) begin : g_msb
         assign head_s   = sreg[WORD_W-1];
         assign head_h   = hold_word[WORD_W-1];
         assign sreg_adv = {sreg[WORD_W-2:0], 1'b0};
         assign hold_adv = {hold_word[WORD_W-2:0], 1'b0};
      end else begin : g_lsb
         assign head_s   = sreg[0];
         assign head_h   = hold_word[0];
         assign sreg_adv = {1'b0, sreg[WORD_W-1:1]};
         assign hold_adv = {1'b0, hold_word[WORD_W-1:1]};
      end
   endgenerate

   always_comb begin
      if (cnt != '0)     src = SRC_SHIFT;
      else if (hold_vld) src = SRC_HOLD;
      else               src = SRC_FILL;
   end

   assign take_o = step && (src == SRC_HOLD);
   assign last_o = step && (src == SRC_SHIFT) && (cnt == CNT_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg       <= '0;
         cnt        <= '0;
         bit_o      <= 1'b0;
         underrun_o <= 1'b0;
      end else if (clr) begin
         sreg       <= '0;
         cnt        <= '0;
         bit_o      <= 1'b0;
         underrun_o <= 1'b0;
      end else if (step) begin
         unique case (src)
            SRC_SHIFT: begin
               bit_o      <= head_s;
               sreg       <= sreg_adv;
               cnt        <= cnt - CNT_ONE;
               underrun_o <= 1'b0;
            end
            SRC_HOLD: begin
               bit_o      <= head_h;
               sreg       <= hold_adv;
               cnt        <= CNT_RELOAD;
               underrun_o <= 1'b0;
            end
            default: begin
               bit_o      <= 1'b0;
               underrun_o <= 1'b1;
            end
         endcase
      end
   end

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(WORD_W));

   // R6
   take_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && !clr) |=> (cnt == CNT_RELOAD));

   // R8
   fill_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && src == SRC_FILL) |=> (underrun_o && !bit_o));
endmodule

// File: rtl/word_serializer.sv
module word_serializer #(
   parameter int WORD_W    = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic              load_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic              bit_req_i,
   output logic              bit_o,
   output logic              word_req_o,
   output logic              underrun_o
);
   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("word_serializer: WORD_W must be at least 2");
      end
   endgenerate

   logic              step, load_ok;
   logic              take, last;
   logic              hold_vld, hold_vld_nxt;
   logic [WORD_W-1:0] hold_word;

   assign step    = bit_req_i && !init_i;
   assign load_ok = load_i && !init_i;

   ws_hold #(.WORD_W(WORD_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (init_i),
      .load   (load_ok),
      .take   (take),
      .data_i (data_i),
      .word_o (hold_word),
      .vld_o  (hold_vld)
   );

   ws_shift #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (init_i),
      .step       (step),
      .hold_vld   (hold_vld),
      .hold_word  (hold_word),
      .take_o     (take),
      .last_o     (last),
      .bit_o      (bit_o),
      .underrun_o (underrun_o)
   );

   assign hold_vld_nxt = load_ok || (hold_vld && !take);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_req_o <= 1'b0;
      else if (init_i) word_req_o <= 1'b0;
      else             word_req_o <= (last || take) && !hold_vld_nxt;
   end

   // R5
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_req_o |=> !word_req_o);

   // R5
   req_vs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_req_o |-> !hold_vld);

   // R9
   init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (!bit_o && !word_req_o && !underrun_o));

   // R2
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && !bit_req_i) |=> $stable(bit_o));
endmodule

// File: tb/sim_word_serializer.sv
module sim_word_serializer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_i = 1'b0;
   logic        load_i = 1'b0;
   logic [15:0] data_i = '0;
   logic        bit_req_i = 1'b0;
   logic        bit_o, word_req_o, underrun_o;
   int          errs = 0;
   int          checks = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   word_serializer #(.WORD_W(16), .MSB_FIRST(1'b1)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_i     (init_i),
      .load_i     (load_i),
      .data_i     (data_i),
      .bit_req_i  (bit_req_i),
      .bit_o      (bit_o),
      .word_req_o (word_req_o),
      .underrun_o (underrun_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock: drive at negedge, outputs sampled at the following negedge
   task automatic step(input logic ld, input logic [15:0] d, input logic rq,
                       input logic in = 1'b0);
      load_i = ld; data_i = d; bit_req_i = rq; init_i = in;
      @(posedge clk);
      @(negedge clk);
      load_i = 1'b0; bit_req_i = 1'b0; init_i = 1'b0;
   endtask

   task automatic shift_word(input logic [15:0] exp, input logic ld1,
                             input logic [15:0] ld_data, input logic req_first,
                             input logic req_last, input string tag);
      logic [15:0] acc = '0;
      for (int i = 0; i < 16; i++) begin
         step(ld1 && i == 1, ld_data, 1'b1);
         acc = {acc[14:0], bit_o};
         if (i == 0)       chk({tag, " R4 word_req after transfer"}, word_req_o, req_first);
         else if (i == 15) chk({tag, " R3 word_req after last bit"}, word_req_o, req_last);
         else if (i == 1)  chk({tag, " R5 pulse ends"}, word_req_o, 1'b0);
      end
      chk({tag, " R1 R6 bits MSB first"}, acc, exp);
   endtask

   task automatic t_reset;
      chk("R9 reset bit_o", bit_o, 1'b0);
      chk("R9 reset word_req", word_req_o, 1'b0);
      chk("R9 reset underrun", underrun_o, 1'b0);
   endtask

   task automatic t_sync_then_data;
      step(1'b1, 16'h0001, 1'b0);
      // R5: held word present, no request pulse yet
      chk("R5 no req while held", word_req_o, 1'b0);
      // early load of the next word during the sync word: R6
      shift_word(16'h0001, 1'b1, 16'hA5C3, 1'b1, 1'b0, "sync");
      chk("R1 sync last bit is one", bit_o, 1'b1);
      shift_word(16'hA5C3, 1'b0, 16'h0, 1'b1, 1'b1, "mixed");
      step(1'b0, 16'h0, 1'b0);
      chk("R3 pulse single cycle", word_req_o, 1'b0);
   endtask

   task automatic t_underrun;
      step(1'b0, 16'h0, 1'b1);
      chk("R8 filler bit", bit_o, 1'b0);
      chk("R8 underrun set", underrun_o, 1'b1);
      step(1'b1, 16'hFFFF, 1'b0);
      step(1'b0, 16'h0, 1'b1);
      chk("R8 real bit after underrun", bit_o, 1'b1);
      chk("R8 underrun cleared", underrun_o, 1'b0);
      for (int k = 0; k < 3; k++) begin
         step(1'b0, 16'h0, 1'b0);
         chk("R2 bit held without request", bit_o, 1'b1);
      end
   endtask

   task automatic t_init_midword;
      // a word is mid-shift here; init with simultaneous load and request
      step(1'b1, 16'h00FF, 1'b1, 1'b1);
      chk("R9 init bit_o", bit_o, 1'b0);
      chk("R9 init word_req", word_req_o, 1'b0);
      chk("R9 init underrun", underrun_o, 1'b0);
      step(1'b0, 16'h0, 1'b1);
      chk("R9 word discarded, load ignored", underrun_o, 1'b1);
      chk("R9 discarded word gives filler", bit_o, 1'b0);
   endtask

   task automatic t_replace;
      step(1'b0, 16'h0, 1'b0, 1'b1);
      step(1'b1, 16'h1234, 1'b0);
      step(1'b1, 16'h8000, 1'b0);
      shift_word(16'h8000, 1'b0, 16'h0, 1'b1, 1'b1, "R7 replace");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sync_then_data();
      t_underrun();
      t_init_midword();
      t_replace();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule